// File: doc/BRIEF.md
# Iterative AES-128 Round Engine (Encrypt and Decrypt)

This block runs the AES-128 cipher or its inverse on one 128-bit block at a time, reusing a single round stage for ten iterations. A block enters as four 32-bit words on a valid/ready stream and is assembled into the state. The round keys are not expanded here. The block drives a round-index output, and an external key source places the matching 128-bit round key on the key port in the same cycle. The result leaves as four 32-bit words on a second valid/ready stream.

The forward round and the inverse round are both built and sit side by side. A direction bit, sampled with the first word of each block, selects which one is used. Blocks of either direction can follow each other directly with no reload or warm-up.

Both streams follow the usual rule: a word moves only in a cycle where valid and ready are both high. The input side holds `in_ready` low from the end of loading until the last result word has left, so words offered in that span stay with the sender. The output side holds its word steady for as long as `out_ready` is low.

Top module: `aes_iter_core`

## Requirements
- R1: Input words are accepted on cycles with `in_valid` and `in_ready` high. The first accepted word is state column 0 and the fourth is column 3. In each word, bits [31:24] carry row 0 and bits [7:0] carry row 3.
- R2: `decrypt` is sampled only with the first accepted word of a block (1 = inverse cipher). Its value during later words has no effect. Consecutive blocks may alternate direction with no extra cycles.
- R3: In the cycle the fourth word is accepted, `rkey_idx` reads 0 for encryption or 10 for decryption, and the assembled block is XORed with `rkey`.
- R4: After loading, exactly ten round cycles follow. In round k (1..10), `rkey_idx` reads k when encrypting and 10-k when decrypting.
- R5: With encryption, the output equals AES-128 of the input under the round keys supplied. Rounds 1 to 9 apply SubBytes, ShiftRows, MixColumns and AddRoundKey, and round 10 omits MixColumns.
- R6: With decryption, each round applies InvShiftRows, InvSubBytes, AddRoundKey and then InvMixColumns, with InvMixColumns left out in the last round, so the output is the AES-128 inverse cipher of the input.
- R7: Result words leave in column order 0 to 3 with the byte layout of R1. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R8: `busy` rises in the cycle after the first input word is accepted and falls in the cycle after the last output word is taken. `in_ready` is low during round and output cycles, and words offered then are not consumed and do not affect the result.
- R9: After reset, `busy` = 0, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| decrypt | input | 1 | Direction for the block, sampled with its first word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_word | input | 32 | Input data word |
| rkey_idx | output | 4 | Index of the round key needed this cycle |
| rkey | input | 128 | Round key selected by `rkey_idx` |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Consumer takes the result word |
| out_word | output | 32 | Result data word |
| busy | output | 1 | A block is in flight |

## Verification
The hardest situation to reach from the ports combines a sender that keeps pushing words during the ten round cycles, a consumer that stalls mid-result, and a `decrypt` pin that flips after the first word. All three must leave the result exact. The bench reaches it by sweeping many blocks while rotating gapped input, junk words offered during rounds and unload, a periodic `out_ready` stall pattern, and inverted `decrypt` on later words. Every result is checked against an AES model computed in the bench, and the round-key index is checked cycle by cycle.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  localparam int BLK_W  = 128;
  localparam int NBYTES = BLK_W / 8;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_UNLOAD} phase_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] t;
    p = '0;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xt(t);
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] t;
    r = 8'h01;
    t = a;
    for (int i = 1; i < 8; i++) begin
      t = gf_mul(t, t);
      r = gf_mul(r, t);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol1(input logic [7:0] x);
    return {x[6:0], x[7]};
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    logic [7:0] acc;
    logic [7:0] t;
    b   = gf_inv(a);
    acc = b;
    t   = b;
    for (int i = 0; i < 4; i++) begin
      t   = rol1(t);
      acc = acc ^ t;
    end
    return acc ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] a);
    logic [7:0] r1;
    logic [7:0] r3;
    logic [7:0] r6;
    r1 = rol1(a);
    r3 = rol1(rol1(r1));
    r6 = rol1(rol1(rol1(r3)));
    return gf_inv(r1 ^ r3 ^ r6 ^ 8'h05);
  endfunction

  function automatic logic [7:0] bget(input logic [BLK_W-1:0] s, input int r, input int c);
    return s[BLK_W-1-8*(4*c+r) -: 8];
  endfunction

  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = bget(s, r, (c + r) % 4);
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] inv_shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = bget(s, r, (c - r + 4) % 4);
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] mix_cols(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = bget(s, 0, c); a1 = bget(s, 1, c);
      a2 = bget(s, 2, c); a3 = bget(s, 3, c);
      o[BLK_W-1-32*c -: 32] = {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                               a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                               a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                               xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    end
    return o;
  endfunction

  function automatic logic [BLK_W-1:0] inv_mix_cols(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = bget(s, 0, c); a1 = bget(s, 1, c);
      a2 = bget(s, 2, c); a3 = bget(s, 3, c);
      o[BLK_W-1-32*c -: 32] =
        {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
         gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
         gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
         gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
    end
    return o;
  endfunction

endpackage

// File: rtl/aes_fwd_round.sv
module aes_fwd_round
  import aes_rnd_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [8*NB-1:0] st,
  input  logic [8*NB-1:0] rk,
  input  logic            last,
  output logic [8*NB-1:0] nxt
);
  logic [8*NB-1:0] sb;
  logic [8*NB-1:0] sr;
  logic [8*NB-1:0] mc;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_sub
      assign sb[8*g +: 8] = sbox(st[8*g +: 8]);
    end
  endgenerate

  assign sr  = shift_rows(sb);
  assign mc  = mix_cols(sr);
  // final round leaves out the column mix (R5)
  assign nxt = (last ? sr : mc) ^ rk;
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_rnd_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [8*NB-1:0] st,
  input  logic [8*NB-1:0] rk,
  input  logic            last,
  output logic [8*NB-1:0] nxt
);
  logic [8*NB-1:0] sr;
  logic [8*NB-1:0] sb;
  logic [8*NB-1:0] ak;

  assign sr = inv_shift_rows(st);

  generate
    for (genvar g = 0; g < NB; g++) begin : g_isub
      assign sb[8*g +: 8] = inv_sbox(sr[8*g +: 8]);
    end
  endgenerate

  assign ak  = sb ^ rk;
  // inverse column mix follows the key add, skipped on the last pass (R6)
  assign nxt = last ? ak : inv_mix_cols(ak);
endmodule

// File: rtl/aes_seq_ctrl.sv
module aes_seq_ctrl
  import aes_rnd_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int NUM_ROUNDS = 10,
  localparam int CNT_W     = $clog2(WORDS),
  localparam int IDX_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output phase_t           phase,
  output logic [CNT_W-1:0] ld_cnt,
  output logic [CNT_W-1:0] ul_cnt,
  output logic [IDX_W-1:0] rnd,
  output logic             in_ready,
  output logic             out_valid,
  output logic             ld_fire,
  output logic             ld_last,
  output logic             round_last,
  output logic             busy
);
  logic ul_fire;

  assign in_ready   = (phase == PH_IDLE) || (phase == PH_LOAD);
  assign out_valid  = (phase == PH_UNLOAD);
  assign busy       = (phase != PH_IDLE);
  assign ld_fire    = in_valid && in_ready;
  assign ul_fire    = out_valid && out_ready;
  assign ld_last    = ld_fire && (phase == PH_LOAD) && (ld_cnt == CNT_W'(WORDS - 1));
  assign round_last = (phase == PH_ROUND) && (rnd == IDX_W'(NUM_ROUNDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      ld_cnt <= '0;
      ul_cnt <= '0;
      rnd    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (ld_fire) begin
          phase  <= PH_LOAD;
          ld_cnt <= CNT_W'(1);
        end
        PH_LOAD: if (ld_fire) begin
          if (ld_last) begin
            phase  <= PH_ROUND;
            ld_cnt <= '0;
            rnd    <= IDX_W'(1);
          end else begin
            ld_cnt <= ld_cnt + CNT_W'(1);
          end
        end
        PH_ROUND: begin
          if (round_last) begin
            phase  <= PH_UNLOAD;
            ul_cnt <= '0;
            rnd    <= '0;
          end else begin
            rnd <= rnd + IDX_W'(1);
          end
        end
        PH_UNLOAD: if (ul_fire) begin
          if (ul_cnt == CNT_W'(WORDS - 1)) begin
            phase  <= PH_IDLE;
            ul_cnt <= '0;
          end else begin
            ul_cnt <= ul_cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: results appear only after the tenth round cycle
  a_r4_ten_rounds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(round_last));

  // R8: busy starts with an accepted word and ends with a taken result word
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready));
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_rnd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int NUM_ROUNDS = 10,
  localparam int WORDS     = BLK_W / WORD_W,
  localparam int CNT_W     = $clog2(WORDS),
  localparam int IDX_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decrypt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [IDX_W-1:0]  rkey_idx,
  input  logic [BLK_W-1:0]  rkey,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              busy
);
  phase_t           phase;
  logic [CNT_W-1:0] ld_cnt;
  logic [CNT_W-1:0] ul_cnt;
  logic [IDX_W-1:0] rnd;
  logic             ld_fire;
  logic             ld_last;
  logic             round_last;
  logic             dir_q;
  logic [BLK_W-1:0] state;
  logic [BLK_W-1:0] load_blk;
  logic [BLK_W-1:0] fwd_nxt;
  logic [BLK_W-1:0] inv_nxt;

  aes_seq_ctrl #(.WORDS(WORDS), .NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .phase      (phase),
    .ld_cnt     (ld_cnt),
    .ul_cnt     (ul_cnt),
    .rnd        (rnd),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .ld_fire    (ld_fire),
    .ld_last    (ld_last),
    .round_last (round_last),
    .busy       (busy)
  );

  aes_fwd_round u_fwd (.st(state), .rk(rkey), .last(round_last), .nxt(fwd_nxt));
  aes_inv_round u_inv (.st(state), .rk(rkey), .last(round_last), .nxt(inv_nxt));

  // key index: initial key on the loading cycle, then ascending or descending
  always_comb begin
    if (phase == PH_ROUND)
      rkey_idx = dir_q ? (IDX_W'(NUM_ROUNDS) - rnd) : rnd;
    else
      rkey_idx = dir_q ? IDX_W'(NUM_ROUNDS) : '0;
  end

  always_comb begin
    load_blk = state;
    load_blk[BLK_W-1-WORD_W*int'(ld_cnt) -: WORD_W] = in_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
      dir_q <= 1'b0;
    end else begin
      if (ld_fire && phase == PH_IDLE) dir_q <= decrypt;
      if (ld_fire) state <= ld_last ? (load_blk ^ rkey) : load_blk;
      else if (phase == PH_ROUND) state <= dir_q ? inv_nxt : fwd_nxt;
    end
  end

  assign out_word = state[BLK_W-1-WORD_W*int'(ul_cnt) -: WORD_W];

  // R4: key index walks by one per round in the block's direction
  a_r4_idx_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ROUND && !round_last) |=>
      (rkey_idx == (dir_q ? $past(rkey_idx) - IDX_W'(1) : $past(rkey_idx) + IDX_W'(1))));

  // R7: a stalled result word is held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R2: direction fixed for the life of a block
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dir_q));

  // R8: nothing is taken while rounds or unloading run
  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ROUND || out_valid) |-> !in_ready);
endmodule

// File: tb/aes_iter_core_tb.sv
`timescale 1ns/1ps
module aes_iter_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         decrypt = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic [3:0]   rkey_idx;
  logic [127:0] rkey;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_word;
  logic         busy;

  int total = 0;
  int fails = 0;
  int rcnt  = 0;
  logic cur_dir = 1'b0;
  logic [127:0] rk [0:15];
  logic [7:0]   sb [0:255];
  logic [7:0]   isb [0:255];
  logic [63:0]  seed = 64'h0123_4567_89ab_cdef;

  always #2.5 clk = ~clk;

  assign rkey = rk[rkey_idx];

  aes_iter_core u_dut (
    .clk(clk), .rst_n(rst_n), .decrypt(decrypt), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .rkey_idx(rkey_idx), .rkey(rkey),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .busy(busy)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // ---- reference model ----
  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mulb(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = m2(x);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] rotb(input logic [7:0] q, input int n);
    return 8'((q << n) | (q >> (8 - n)));
  endfunction

  function automatic void build_sbox();
    logic [7:0] p = 1;
    logic [7:0] q = 1;
    do begin
      p = p ^ m2(p) ^ 8'h00;
      p = p ^ 8'h00;
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rotb(q, 1) ^ rotb(q, 2) ^ rotb(q, 3) ^ rotb(q, 4) ^ 8'h63;
    end while (p != 1);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
  endfunction

  function automatic logic [7:0] by(input logic [127:0] s, input int r, input int c);
    return s[127 - 8*(4*c + r) -: 8];
  endfunction

  function automatic logic [127:0] m_sub(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = inv ? isb[s[8*i +: 8]] : sb[s[8*i +: 8]];
    return o;
  endfunction

  function automatic logic [127:0] m_shift(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8*(4*c + r) -: 8] = by(s, r, inv ? (c + 4 - r) % 4 : (c + r) % 4);
    return o;
  endfunction

  function automatic logic [127:0] m_mix(input logic [127:0] s, input bit inv);
    logic [7:0] cf [4];
    logic [127:0] o;
    logic [7:0] acc;
    if (inv) cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     cf = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        acc = 0;
        for (int k = 0; k < 4; k++) acc ^= mulb(cf[(k - r + 4) % 4], by(s, k, c));
        o[127 - 8*(4*c + r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic void expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 16; r++) rk[r] = '0;
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  function automatic logic [127:0] ref_run(input logic [127:0] b, input bit dec);
    logic [127:0] s;
    if (!dec) begin
      s = b ^ rk[0];
      for (int r = 1; r <= 10; r++) begin
        s = m_shift(m_sub(s, 0), 0);
        if (r < 10) s = m_mix(s, 0);
        s = s ^ rk[r];
      end
    end else begin
      s = b ^ rk[10];
      for (int r = 9; r >= 0; r--) begin
        s = m_sub(m_shift(s, 1), 1) ^ rk[r];
        if (r > 0) s = m_mix(s, 1);
      end
    end
    return s;
  endfunction

  function automatic logic [63:0] rnd64();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  // R4: key index observed in every round cycle
  always @(negedge clk) begin
    if (rst_n && busy && !in_ready && !out_valid) begin
      chk("R4 round key index", 128'(rkey_idx),
          cur_dir ? 128'(10 - (rcnt + 1)) : 128'(rcnt + 1));
      rcnt++;
    end
  end

  task automatic run_block(input logic [127:0] blk, input bit dir, input bit gap,
                           input bit stall, input bit junk, output logic [127:0] res);
    logic [127:0] exp;
    bit acc;
    int got = 0;
    int k = 0;
    bit held = 0;
    logic [31:0] held_w = '0;
    cur_dir = dir;
    rcnt = 0;
    exp = ref_run(blk, dir);
    for (int i = 0; i < 4; i++) begin
      if (gap && i[0]) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_word  = blk[127 - 32*i -: 32];
      decrypt  = (i == 0) ? dir : !dir;
      if (i == 3) chk("R3 initial key index", 128'(rkey_idx), dir ? 128'd10 : 128'd0);
      do begin
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
      if (i == 0) chk("R8 busy after first word", 128'(busy), 128'd1);
    end
    in_valid = junk;
    in_word  = 32'hdead_beef;
    decrypt  = !dir;
    while (got < 4 && k < 200) begin
      if (held) chk("R7 stalled word held", {95'd0, out_valid, out_word}, {95'd0, 1'b1, held_w});
      if (out_valid && got == 0 && held == 0) chk("R8 in_ready low in output", 128'(in_ready), 128'd0);
      out_ready = stall ? (k % 3 == 2) : 1'b1;
      held = out_valid && !out_ready;
      held_w = out_word;
      if (out_valid && out_ready) begin
        res[127 - 32*got -: 32] = out_word;
        got++;
      end
      k++;
      @(negedge clk);
    end
    in_valid = 0;
    out_ready = 0;
    chk("R8 busy low after last word", 128'(busy), 128'd0);
    chk("R4 ten round cycles", 128'(rcnt), 128'd10);
    if (dir) chk("R1 R6 R7 R2 decrypt result", res, exp);
    else     chk("R1 R5 R7 R2 encrypt result", res, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [127:0] r;
    logic [127:0] key;
    logic [127:0] blk;
    build_sbox();
    expand(128'h000102030405060708090a0b0c0d0e0f);
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 128'(busy), 128'd0);
    chk("R9 reset out_valid", 128'(out_valid), 128'd0);
    chk("R9 reset in_ready", 128'(in_ready), 128'd1);
    rst_n = 1;
    @(negedge clk);

    // known vector
    run_block(128'h00112233445566778899aabbccddeeff, 0, 0, 0, 0, r);
    chk("R5 known answer", r, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1, 1, 1, 1, r);
    chk("R6 known answer", r, 128'h00112233445566778899aabbccddeeff);

    // sweep: alternating directions, gaps, stalls, junk input
    key = '0;
    for (int n = 0; n < 48; n++) begin
      if (n % 8 == 0) begin
        key = {rnd64(), rnd64()};
        expand(key);
      end
      blk = {rnd64(), rnd64()};
      run_block(blk, n[0] ^ n[3], n % 3 == 1, n % 4 == 2, n % 5 == 3, r);
    end
    report();
  end
endmodule